// File: doc/BRIEF.md
# Layered Write Protection Controller for a 256-Byte Nonvolatile Array

This block decides, for a byte array behind a two-wire serial front end, which addresses may be written. Three protection layers are combined. A hardware protect pin locks the whole array while it is high. A one-time permanent flag locks the lower half of the array and can never be cleared. A reversible flag also locks the lower half, and it can be set and cleared again by special commands. Both flags sit in flops that keep their value across the soft reset, which models nonvolatile storage. Only a separate initialisation input clears them.

The front end hands over a control byte that it has already parsed. That byte is split into a 4-bit nibble, three select bits and a read/write bit. The front end also supplies the levels of the three address pins and a flag that says a high voltage is present on pin 0. The block answers each control byte one cycle later with an acknowledge or a no-acknowledge. When the front end sees the stop condition that ends a write sequence, it pulses `wr_stop`. On that pulse the block commits any protect-flag update that was armed and starts the self-timed busy period. For any address on `probe_addr`, the block drives a combinational write-enable that the array uses to keep or discard incoming data.

Top module: `nvwp_guard`

## Requirements
- R1: For every cycle with `cmd_valid` high, `ack_valid` is high in the following cycle, and `ack_out` then gives the decision. In every other cycle, `ack_valid` and `ack_out` are both low.
- R2: Outside a busy period, nibble 4'b1010 is acknowledged exactly when `cmd_sel` equals `pin_lvl`. Any nibble other than 4'b1010 or 4'b0110 is never acknowledged.
- R3: While `wp_pin` is high, `wr_allow` is low for every address.
- R4: While either flag is set and `wp_pin` is low, `wr_allow` is low when the address MSB is 0 and high when the address MSB is 1. With both flags clear and `wp_pin` low, every address is allowed.
- R5: The permanent-flag command is nibble 0110 with `cmd_sel` equal to `pin_lvl` and `a0_hv` low. When the flag is clear, this command is acknowledged, and its stop sets the flag. Once the flag is set, the command is not acknowledged in either direction. The flag survives `rst_n` and is cleared only by `nv_init`.
- R6: The reversible flag is set by nibble 0110, select 3'b001 and write, with `a0_hv` high and pins 2 and 1 low. It is cleared by nibble 0110, select 3'b011 and write, with `a0_hv` high, pin 2 low and pin 1 high. The clear command is always acknowledged. The flag changes at the following stop, and it survives `rst_n`.
- R7: A status query is the set command with the read bit high. It is acknowledged exactly when the flag it addresses is clear.
- R8: While `wp_pin` is high, a protect command is answered as it would be with the pin low, but neither flag changes.
- R9: A stop after an accepted array write or an accepted flag update starts a busy period of `BUSY_CYCLES` cycles. This holds even when the address written is protected. Every command sampled during that period is not acknowledged.
- R10: A refused protect command starts no busy period when its stop arrives, so the next command is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset (leaves the flags untouched) |
| nv_init | input | 1 | Initialisation of the nonvolatile flags, simulation only |
| cmd_valid | input | 1 | One-cycle pulse: parsed control byte present |
| cmd_nib | input | 4 | Upper nibble of the control byte |
| cmd_sel | input | 3 | Select bits of the control byte (positions 3..1) |
| cmd_rd | input | 1 | Read/write bit, 1 = read |
| pin_lvl | input | 3 | Address pin levels, bit 2 down to bit 0 |
| a0_hv | input | 1 | High voltage detected on address pin 0 |
| wp_pin | input | 1 | Hardware protect pin |
| wr_stop | input | 1 | Stop condition that ends a write sequence |
| probe_addr | input | ADDR_W | Address whose write permission is queried |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack_out | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| wr_allow | output | 1 | Write to `probe_addr` is permitted |

## Verification
The bench builds the block with the default 8-bit address and a short busy period of 6 cycles. With that setting, the whole busy window can be crossed, and probed inside and just past its end, in a few dozen cycles. With an 8-bit address, random probes land in both halves of the array often. Random command phases run first with both flags clear and again after the permanent flag is set. Between these phases, directed sequences cover every set, clear and query path, both with the hardware pin low and with it high.

// File: rtl/nvwp_pkg.sv
package nvwp_pkg;
   localparam logic [3:0] NIB_ARRAY = 4'b1010;
   localparam logic [3:0] NIB_PROT  = 4'b0110;
   localparam logic [2:0] SEL_RSET  = 3'b001;
   localparam logic [2:0] SEL_RCLR  = 3'b011;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_ARRAY,
      OP_PSET,
      OP_RSET,
      OP_RCLR
   } op_e;
endpackage

// File: rtl/nvwp_decode.sv
module nvwp_decode
   import nvwp_pkg::*;
(
   input  logic [3:0] nib,
   input  logic [2:0] sel,
   input  logic       rd,
   input  logic [2:0] pin_lvl,
   input  logic       a0_hv,
   input  logic       wp_pin,
   input  logic       pswp,
   input  logic       rswp,
   input  logic       busy,
   output logic       ack_d,
   output op_e        arm_op
);
   always_comb begin
      ack_d  = 1'b0;
      arm_op = OP_NONE;
      if (!busy) begin
         if (nib == NIB_ARRAY) begin
            if (sel == pin_lvl) begin
               ack_d = 1'b1;
               if (!rd) arm_op = OP_ARRAY;
            end
         end else if (nib == NIB_PROT) begin
            if (a0_hv) begin
               if (sel == SEL_RSET && pin_lvl[2:1] == 2'b00) begin
                  ack_d = !rswp;
                  if (!rd && !rswp && !wp_pin) arm_op = OP_RSET;
               end else if (sel == SEL_RCLR && !rd && pin_lvl[2:1] == 2'b01) begin
                  ack_d = 1'b1;
                  if (rswp && !wp_pin) arm_op = OP_RCLR;
               end
            end else if (sel == pin_lvl) begin
               ack_d = !pswp;
               if (!rd && !pswp && !wp_pin) arm_op = OP_PSET;
            end
         end
      end
   end
endmodule

// File: rtl/nvwp_flags.sv
module nvwp_flags
   import nvwp_pkg::*;
(
   input  logic clk,
   input  logic nv_init,
   input  logic commit,
   input  op_e  op,
   output logic pswp,
   output logic rswp
);
   // No soft reset here: these flops stand in for nonvolatile cells.
   always_ff @(posedge clk) begin
      if (nv_init) begin
         pswp <= 1'b0;
         rswp <= 1'b0;
      end else if (commit) begin
         case (op)
            OP_PSET: pswp <= 1'b1;
            OP_RSET: rswp <= 1'b1;
            OP_RCLR: rswp <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/nvwp_busy.sv
module nvwp_busy #(
   parameter int BUSY_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad
         $error("nvwp_busy: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= CNT_W'(BUSY_CYCLES);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvwp_guard.sv
module nvwp_guard
   import nvwp_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int BUSY_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_init,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_nib,
   input  logic [2:0]        cmd_sel,
   input  logic              cmd_rd,
   input  logic [2:0]        pin_lvl,
   input  logic              a0_hv,
   input  logic              wp_pin,
   input  logic              wr_stop,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              ack_valid,
   output logic              ack_out,
   output logic              wr_allow
);
   localparam int TOP_BIT = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("nvwp_guard: ADDR_W must be at least 2");
      end
   endgenerate

   logic pswp, rswp, busy, ack_d, commit;
   op_e  arm_op, pend_q;

   nvwp_decode dec_i (
      .nib(cmd_nib), .sel(cmd_sel), .rd(cmd_rd), .pin_lvl(pin_lvl),
      .a0_hv(a0_hv), .wp_pin(wp_pin), .pswp(pswp), .rswp(rswp),
      .busy(busy), .ack_d(ack_d), .arm_op(arm_op)
   );

   // A write sequence is armed by its control byte and takes effect at its stop.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= OP_NONE;
      else if (cmd_valid) pend_q <= arm_op;
      else if (wr_stop)   pend_q <= OP_NONE;
   end

   assign commit = wr_stop && (pend_q != OP_NONE);

   nvwp_flags flags_i (
      .clk(clk), .nv_init(nv_init), .commit(commit), .op(pend_q),
      .pswp(pswp), .rswp(rswp)
   );

   nvwp_busy #(.BUSY_CYCLES(BUSY_CYCLES)) busy_i (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_out   <= 1'b0;
      end else begin
         ack_valid <= cmd_valid;
         ack_out   <= cmd_valid && ack_d;
      end
   end

   assign wr_allow = !wp_pin && !(!probe_addr[TOP_BIT] && (pswp || rswp));
endmodule

// File: rtl/nvwp_guard_chk.sv
module nvwp_guard_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nv_init,
   input logic              cmd_valid,
   input logic [3:0]        cmd_nib,
   input logic [2:0]        cmd_sel,
   input logic              cmd_rd,
   input logic [2:0]        pin_lvl,
   input logic              a0_hv,
   input logic              wp_pin,
   input logic              wr_stop,
   input logic [ADDR_W-1:0] probe_addr,
   input logic              ack_valid,
   input logic              ack_out,
   input logic              wr_allow,
   input logic              pswp,
   input logic              rswp,
   input logic              busy
);
   logic perm_hit;
   assign perm_hit = cmd_valid && cmd_nib == 4'b0110 && !a0_hv && cmd_sel == pin_lvl
                     && (cmd_rd || !cmd_rd);

   AST_ACK_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> ack_valid); // R1
   AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (!ack_valid && !ack_out)); // R1
   AST_WP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n || nv_init)
      wp_pin |-> !wr_allow); // R3
   AST_LOW_HALF_LOCK: assert property (@(posedge clk) disable iff (!rst_n || nv_init)
      ((pswp || rswp) && !probe_addr[ADDR_W-1]) |-> !wr_allow); // R4
   AST_PERM_STICKY: assert property (@(posedge clk) disable iff (nv_init)
      pswp |=> pswp); // R5
   AST_PERM_NACK: assert property (@(posedge clk) disable iff (!rst_n || nv_init)
      (perm_hit && pswp) |=> !ack_out); // R5
   AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n || nv_init)
      (busy && cmd_valid) |=> !ack_out); // R9
   AST_FLAGS_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n || nv_init)
      !wr_stop |=> ($stable(pswp) && $stable(rswp))); // R8
endmodule

bind nvwp_guard nvwp_guard_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/nvwp_guard_tb_top.sv
module nvwp_guard_tb_top;
   localparam int AW   = 8;
   localparam int BUSY = 6;

   logic clk = 1'b0;
   logic rst_n, nv_init, cmd_valid, cmd_rd, a0_hv, wp_pin, wr_stop;
   logic [3:0] cmd_nib;
   logic [2:0] cmd_sel, pin_lvl;
   logic [AW-1:0] probe_addr;
   logic ack_valid, ack_out, wr_allow;

   int total = 0, bad = 0;
   bit done = 0;
   bit pswp_m = 0, rswp_m = 0;

   always #5 clk = ~clk;

   nvwp_guard #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .cmd_valid(cmd_valid),
      .cmd_nib(cmd_nib), .cmd_sel(cmd_sel), .cmd_rd(cmd_rd), .pin_lvl(pin_lvl),
      .a0_hv(a0_hv), .wp_pin(wp_pin), .wr_stop(wr_stop), .probe_addr(probe_addr),
      .ack_valid(ack_valid), .ack_out(ack_out), .wr_allow(wr_allow)
   );

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic bit exp_ack(logic [3:0] n, logic [2:0] s, logic r,
                                  logic [2:0] p, logic hv);
      if (n == 4'b1010) return s == p;
      if (n == 4'b0110) begin
         if (hv) begin
            if (s == 3'b001 && p[2:1] == 2'b00) return !rswp_m;
            if (s == 3'b011 && !r && p[2:1] == 2'b01) return 1'b1;
            return 1'b0;
         end
         return (s == p) ? !pswp_m : 1'b0;
      end
      return 1'b0;
   endfunction

   function automatic bit exp_allow(logic [AW-1:0] a, logic wp);
      if (wp) return 1'b0;
      if (!a[AW-1] && (pswp_m || rswp_m)) return 1'b0;
      return 1'b1;
   endfunction

   // Called at a negedge; returns at the next negedge with the answer visible.
   task automatic send(logic [3:0] n, logic [2:0] s, logic r, logic [2:0] p, logic hv,
                       output logic av, output logic ak);
      cmd_nib = n; cmd_sel = s; cmd_rd = r; pin_lvl = p; a0_hv = hv; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      av = ack_valid; ak = ack_out;
   endtask

   task automatic stop();
      wr_stop = 1'b1;
      @(negedge clk);
      wr_stop = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic probe(string req, logic [AW-1:0] a);
      probe_addr = a;
      #1;
      check(req, wr_allow, exp_allow(a, wp_pin));
   endtask

   task automatic soft_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic rand_phase(int n);
      logic av, ak;
      for (int i = 0; i < n; i++) begin
         logic [3:0] nb;
         logic [2:0] s, p;
         logic r, hv;
         int k;
         k = $urandom_range(0, 3);
         nb = (k == 0) ? 4'($urandom) : ((k == 1) ? 4'b1010 : 4'b0110);
         p = 3'($urandom);
         s = ($urandom_range(0, 1) == 1) ? p : 3'($urandom);
         r = 1'($urandom);
         hv = 1'($urandom);
         wp_pin = 1'($urandom);
         send(nb, s, r, p, hv, av, ak);
         check("R1 ack_valid", av, 1'b1);
         check("R2/R5/R6/R7 random ack", ak, exp_ack(nb, s, r, p, hv));
         probe("R3/R4 random wr_allow", AW'($urandom));
      end
      wp_pin = 1'b0;
   endtask

   initial begin
      logic av, ak;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; nv_init = 1'b1; cmd_valid = 1'b0; cmd_nib = '0; cmd_sel = '0;
      cmd_rd = 1'b0; pin_lvl = '0; a0_hv = 1'b0; wp_pin = 1'b0; wr_stop = 1'b0;
      probe_addr = '0;
      idle(3);
      nv_init = 1'b0; rst_n = 1'b1;
      idle(1);
      check("R1 reset ack_valid", ack_valid, 1'b0);
      check("R1 reset ack_out", ack_out, 1'b0);
      probe("R4 clear flags low addr", 8'h00);

      // R2 array decode
      send(4'b1010, 3'b101, 1'b1, 3'b101, 1'b0, av, ak);
      check("R1 ack_valid", av, 1'b1);
      check("R2 matching array read", ak, 1'b1);
      send(4'b1010, 3'b100, 1'b1, 3'b101, 1'b0, av, ak);
      check("R2 select mismatch", ak, 1'b0);
      send(4'b1110, 3'b000, 1'b0, 3'b000, 1'b0, av, ak);
      check("R2 foreign nibble", ak, 1'b0);

      // R7 status queries with both flags clear
      send(4'b0110, 3'b010, 1'b1, 3'b010, 1'b0, av, ak);
      check("R7 permanent query clear", ak, 1'b1);
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1, av, ak);
      check("R7 reversible query clear", ak, 1'b1);

      rand_phase(150);

      // R8 / R10: hardware pin high refuses the permanent set
      wp_pin = 1'b1;
      probe("R3 wp blocks upper", 8'h90);
      send(4'b0110, 3'b000, 1'b0, 3'b000, 1'b0, av, ak);
      check("R8 set under wp still acked", ak, 1'b1);
      stop();
      send(4'b0110, 3'b000, 1'b1, 3'b000, 1'b0, av, ak);
      check("R10 no busy after refused set", ak, 1'b1);
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1, av, ak);
      stop();
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1, av, ak);
      check("R8 reversible flag unchanged under wp", ak, 1'b1);
      wp_pin = 1'b0;
      probe("R8 flags still clear", 8'h10);

      // R6 set reversible flag, R9 busy
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1, av, ak);
      check("R6 set reversible acked", ak, 1'b1);
      stop();
      rswp_m = 1;
      send(4'b1010, 3'b000, 1'b1, 3'b000, 1'b0, av, ak);
      check("R9 nack during busy", ak, 1'b0);
      idle(BUSY + 1);
      send(4'b1010, 3'b000, 1'b1, 3'b000, 1'b0, av, ak);
      check("R9 ack after busy", ak, 1'b1);
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1, av, ak);
      check("R7 reversible query set", ak, 1'b0);
      probe("R4 low half locked", 8'h10);
      probe("R4 upper half open", 8'h80);
      soft_reset();
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1, av, ak);
      check("R6 reversible flag survives rst_n", ak, 1'b0);

      // R6 clear
      send(4'b0110, 3'b011, 1'b0, 3'b011, 1'b1, av, ak);
      check("R6 clear acked", ak, 1'b1);
      stop();
      rswp_m = 0;
      idle(BUSY + 1);
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1, av, ak);
      check("R6 reversible cleared", ak, 1'b1);
      probe("R4 low half reopened", 8'h10);

      // R5 permanent flag
      send(4'b0110, 3'b110, 1'b0, 3'b110, 1'b0, av, ak);
      check("R5 permanent set acked", ak, 1'b1);
      stop();
      pswp_m = 1;
      idle(BUSY + 1);
      send(4'b0110, 3'b110, 1'b1, 3'b110, 1'b0, av, ak);
      check("R5/R7 permanent query set", ak, 1'b0);
      send(4'b0110, 3'b110, 1'b0, 3'b110, 1'b0, av, ak);
      check("R5 repeat set nacked", ak, 1'b0);
      soft_reset();
      send(4'b0110, 3'b110, 1'b1, 3'b110, 1'b0, av, ak);
      check("R5 permanent survives rst_n", ak, 1'b0);
      probe("R4 last low byte locked", 8'h7F);
      probe("R4 first upper byte open", 8'h80);

      // R9 protected array write still runs the busy period
      send(4'b1010, 3'b110, 1'b0, 3'b110, 1'b0, av, ak);
      check("R9 protected write acked", ak, 1'b1);
      stop();
      send(4'b1010, 3'b110, 1'b1, 3'b110, 1'b0, av, ak);
      check("R9 busy after protected write", ak, 1'b0);
      idle(BUSY + 1);

      rand_phase(150);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule